// File: doc/BRIEF.md
# Cycle Counter with Compare Timers

This block keeps a 32-bit count of core cycles and holds a set of compare registers. The number of compare registers is set by a parameter. Each compare register has its own pending-interrupt bit. The count advances by one on every clock while `countEn` is high. It wraps from all-ones to zero, and there is no prescaler.

Software uses one write port and one read port. The write select chooses the target: select 0 is the counter, and select k (1 to NUM_CMP) is compare register k-1. Writing the counter only moves the count; the compare values and pending bits stay as they are. Writing a compare register loads a new value and clears that comparator's pending bit.

A comparator fires on the clock edge where the count advances onto its value. So a compare value that equals the count at the moment it is written, or a count written straight onto a compare value, does not fire at once. It fires only after the counter has advanced a full 2^32 steps. Interrupt priority, masking and the processor side are handled elsewhere.

Top module: `cycle_compare_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the count, every compare register and every pending bit at the next rising edge.
- R2: With `countEn` high and no counter write, `countOut` rises by exactly one per clock. With `countEn` low it holds.
- R3: After the count reaches 0xFFFFFFFF, the next advance gives 0x00000000.
- R4: A write with `wrSel` = 0 puts `wrData` into the count at that edge, whatever `countEn` is. Counting then continues from that value.
- R5: Bit k of `irqPending` sets on the edge where the count advances to a value equal to compare register k. It stays set, through further counting and counter writes, until compare register k is written.
- R6: A write with `wrSel` = k+1 loads compare register k and clears bit k of `irqPending` at that same edge. The other pending bits are left unchanged.
- R7: A comparator does not fire when its compare value equals the count at the time it is written. It also does not fire when a counter write lands the count on its compare value. A match is only produced by an advance.
- R8: A counter write leaves every compare register and every pending bit unchanged.
- R9: `rdData` is combinational. `rdSel` = 0 returns the count, `rdSel` = k+1 returns compare register k, and any other select returns zero.
- R10: A write whose select is above NUM_CMP changes neither the count flow nor any compare register or pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| countEn | input | 1 | Advance the count this cycle |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | SEL_W | Write target: 0 counter, k+1 compare k |
| wrData | input | CNT_W | Write value |
| rdSel | input | SEL_W | Read target, same encoding as wrSel |
| rdData | output | CNT_W | Selected register value |
| countOut | output | CNT_W | Current count |
| irqPending | output | NUM_CMP | Pending timer interrupt, one bit per comparator |

## Verification
The hardest cases to reach are the ones that depend on the 32-bit wrap: a compare value that only matches after the count rolls over, and a match that must not fire because the compare equals the count. Waiting 2^32 cycles is not possible in simulation. Instead, the stimulus uses counter writes to jump the count to just below all-ones, with a compare value just past zero. The no-fire cases are set up by writing a compare value equal to the live count, and by writing the count directly onto an armed compare value.

// File: rtl/cycle_compare_timer_pkg.sv
package cycle_compare_timer_pkg;
  // Strobes passed from control to datapath for the counter.
  typedef struct packed {
    logic load;     // take wrData into the count
    logic advance;  // count plus one
  } cnt_strobe_t;
endpackage

// File: rtl/cycle_compare_timer_ctrl.sv
module cycle_compare_timer_ctrl
  import cycle_compare_timer_pkg::*;
#(
  parameter int NUM_CMP = 2,
  parameter int SEL_W   = 2
) (
  input  logic               countEn,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  output cnt_strobe_t        cntStb,
  output logic [NUM_CMP-1:0] cmpWr
);
  logic loadHit;

  // A counter write takes priority over the increment.
  assign loadHit        = wrEn && (wrSel == '0);
  assign cntStb.load    = loadHit;
  assign cntStb.advance = countEn && !loadHit;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmpDec
    assign cmpWr[k] = wrEn && (wrSel == SEL_W'(k + 1));
  end
endmodule

// File: rtl/cycle_compare_timer_dp.sv
module cycle_compare_timer_dp
  import cycle_compare_timer_pkg::*;
#(
  parameter int NUM_CMP = 2,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  cnt_strobe_t        cntStb,
  input  logic [NUM_CMP-1:0] cmpWr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [CNT_W-1:0]   countOut,
  output logic [CNT_W-1:0]   rdData,
  output logic [NUM_CMP-1:0] irqPending
);
  localparam int FLAT_W = NUM_CMP * CNT_W;

  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  countNext;
  logic [FLAT_W-1:0] cmpFlat;

  // Natural wrap from all-ones to zero.
  assign countNext = countQ + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                 countQ <= '0;
    else if (cntStb.load)    countQ <= wrData;
    else if (cntStb.advance) countQ <= countNext;
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic [CNT_W-1:0] cmpReg;
    logic             pendReg;

    // A match happens only when an advance lands the count on the compare
    // value, so an equal value set by a write waits a full wrap.
    always_ff @(posedge clk) begin
      if (rst) begin
        cmpReg  <= '0;
        pendReg <= 1'b0;
      end else if (cmpWr[k]) begin
        cmpReg  <= wrData;
        pendReg <= 1'b0;
      end else if (cntStb.advance && (countNext == cmpReg)) begin
        pendReg <= 1'b1;
      end
    end

    assign cmpFlat[k*CNT_W +: CNT_W] = cmpReg;
    assign irqPending[k]             = pendReg;
  end

  always_comb begin
    rdData = '0;
    if (rdSel == '0) rdData = countQ;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (rdSel == SEL_W'(k + 1)) rdData = cmpFlat[k*CNT_W +: CNT_W];
    end
  end

  assign countOut = countQ;
endmodule

// File: rtl/cycle_compare_timer.sv
module cycle_compare_timer
  import cycle_compare_timer_pkg::*;
#(
  parameter int  NUM_CMP = 2,
  parameter int  CNT_W   = 32,
  localparam int SEL_W   = $clog2(NUM_CMP + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               countEn,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [CNT_W-1:0]   rdData,
  output logic [CNT_W-1:0]   countOut,
  output logic [NUM_CMP-1:0] irqPending
);
  cnt_strobe_t        cntStb;
  logic [NUM_CMP-1:0] cmpWr;

  cycle_compare_timer_ctrl #(.NUM_CMP(NUM_CMP), .SEL_W(SEL_W)) ctrl_i (
    .countEn (countEn),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .cntStb  (cntStb),
    .cmpWr   (cmpWr)
  );

  cycle_compare_timer_dp #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W), .SEL_W(SEL_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .cntStb     (cntStb),
    .cmpWr      (cmpWr),
    .wrData     (wrData),
    .rdSel      (rdSel),
    .countOut   (countOut),
    .rdData     (rdData),
    .irqPending (irqPending)
  );
endmodule

// File: rtl/cycle_compare_timer_chk.sv
module cycle_compare_timer_chk #(
  parameter int NUM_CMP = 2,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               countEn,
  input logic               wrEn,
  input logic [SEL_W-1:0]   wrSel,
  input logic [CNT_W-1:0]   wrData,
  input logic [CNT_W-1:0]   countOut,
  input logic [NUM_CMP-1:0] irqPending
);
  logic cntWrite;
  assign cntWrite = wrEn && (wrSel == '0);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (countOut == '0) && (irqPending == '0)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (countEn && !cntWrite) |=> countOut == CNT_W'($past(countOut) + CNT_W'(1))); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!countEn && !cntWrite) |=> $stable(countOut)); // R2

  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    cntWrite |=> countOut == $past(wrData)); // R4

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_chk
    AST_CMP_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (wrEn && wrSel == SEL_W'(k + 1)) |=> !irqPending[k]); // R6

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
      (irqPending[k] && !(wrEn && wrSel == SEL_W'(k + 1))) |=> irqPending[k]); // R5

    AST_NO_FIRE_WITHOUT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (!irqPending[k] && !(countEn && !cntWrite)) |=> !irqPending[k]); // R7
  end
endmodule

bind cycle_compare_timer cycle_compare_timer_chk #(
  .NUM_CMP(NUM_CMP), .CNT_W(CNT_W), .SEL_W(SEL_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .countEn    (countEn),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .countOut   (countOut),
  .irqPending (irqPending)
);

// File: tb/cycle_compare_timer_tb_top.sv
module cycle_compare_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CMP    = 2;
  localparam int CNT_W      = 32;
  localparam int SEL_W      = $clog2(NUM_CMP + 1);

  logic               clk = 1'b0;
  logic               rst;
  logic               countEn;
  logic               wrEn;
  logic [SEL_W-1:0]   wrSel;
  logic [CNT_W-1:0]   wrData;
  logic [SEL_W-1:0]   rdSel;
  logic [CNT_W-1:0]   rdData;
  logic [CNT_W-1:0]   countOut;
  logic [NUM_CMP-1:0] irqPending;

  typedef struct {
    int          kind;   // 0 count, 1 pending vector, 2 read data
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t    sbq[$];
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;
  logic [31:0] expCount;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cycle_compare_timer #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .countEn(countEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .countOut(countOut),
    .irqPending(irqPending)
  );

  // Monitor: pops expected items and compares against the live outputs.
  initial begin
    forever begin
      sb_item_t it;
      logic [31:0] act;
      wait (sbq.size() != 0);
      it = sbq.pop_front();
      case (it.kind)
        0:       act = countOut;
        1:       act = 32'(irqPending);
        default: act = rdData;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string req);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic exp_count(input string req);
    push(0, expCount, req);
  endtask

  task automatic exp_pend(input logic [NUM_CMP-1:0] v, input string req);
    push(1, 32'(v), req);
  endtask

  task automatic exp_rd(input logic [SEL_W-1:0] sel, input logic [31:0] v, input string req);
    rdSel = sel;
    #1;
    push(2, v, req);
  endtask

  // Driver: one clock with the given inputs; updates the bench count model.
  task automatic step(input bit en, input bit we, input logic [SEL_W-1:0] ws,
                      input logic [31:0] wd);
    countEn = en; wrEn = we; wrSel = ws; wrData = wd;
    @(posedge clk);
    @(negedge clk);
    if (rst)                 expCount = '0;
    else if (we && ws == '0) expCount = wd;
    else if (en)             expCount = expCount + 32'd1;
    wrEn = 1'b0;
  endtask

  initial begin
    rst = 1'b1; countEn = 1'b0; wrEn = 1'b0; wrSel = '0; wrData = '0; rdSel = '0;
    expCount = '0;
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    exp_count("R1"); exp_pend(2'b00, "R1");
    exp_rd(1, 0, "R1"); exp_rd(2, 0, "R1");
    rst = 1'b0;

    for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
    exp_count("R2");                       // 5
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    exp_count("R2");                       // held at 5

    step(1, 1, 0, 32'd100);  exp_count("R4");   // write wins over increment
    step(1, 0, 0, 0);        exp_count("R4");   // 101

    step(1, 1, 1, 32'd104);  exp_count("R2");   // 102
    exp_rd(1, 32'd104, "R9"); exp_rd(0, 32'd102, "R9");
    step(1, 1, 2, 32'd105);                     // 103
    exp_pend(2'b00, "R5");
    step(1, 0, 0, 0);        exp_pend(2'b01, "R5");  // 104
    step(1, 0, 0, 0);        exp_pend(2'b11, "R5");  // 105
    step(1, 0, 0, 0);        exp_pend(2'b11, "R5");  // sticky at 106

    step(1, 1, 0, 32'd200);  exp_count("R8");
    exp_pend(2'b11, "R8");
    exp_rd(1, 32'd104, "R8"); exp_rd(2, 32'd105, "R8");

    step(1, 1, 1, 32'd300);  exp_pend(2'b10, "R6");  // count 201
    exp_rd(1, 32'd300, "R6");

    step(1, 1, 3, 32'h55);   exp_count("R10");       // 202
    exp_pend(2'b10, "R10");
    exp_rd(1, 32'd300, "R10"); exp_rd(2, 32'd105, "R10");
    exp_rd(3, 32'd0, "R9");

    // Compare equal to the live count when written: no immediate fire.
    step(1, 1, 1, 32'd202);  exp_pend(2'b10, "R7");  // count 203
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    exp_pend(2'b10, "R7");
    // Counter written onto an armed compare value: no fire.
    step(1, 1, 0, 32'd202);  exp_pend(2'b10, "R7");
    step(1, 0, 0, 0);        exp_pend(2'b10, "R7");  // 203

    // Wrap and a match just past zero.
    step(1, 1, 1, 32'd1);                            // 204
    step(1, 1, 0, 32'hFFFF_FFFE);  exp_count("R4");
    step(1, 0, 0, 0);        exp_count("R3");        // FFFFFFFF
    step(1, 0, 0, 0);        exp_count("R3");        // 0
    exp_pend(2'b10, "R3");
    step(1, 0, 0, 0);        exp_pend(2'b11, "R5");  // 1 -> fire

    step(0, 1, 0, 32'd77);   exp_count("R4");        // load with countEn low
    step(0, 0, 0, 0);        exp_count("R4");

    rst = 1'b1;
    step(1, 0, 0, 0);
    exp_count("R1"); exp_pend(2'b00, "R1");
    exp_rd(1, 0, "R1"); exp_rd(2, 0, "R1");
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule